// File: doc/BRIEF.md
# Transmit Bid and Start Controller

This block stands between a host register interface and an Ethernet transmit buffer. For every frame the host first writes a command: a 2-bit start selector plus four option bits. It then writes the frame length. A valid length arms the bid. Once the MAC is idle, the block raises a ready flag, which can also drive an interrupt. The host then streams frame bytes into the buffer, and the block counts them.

When the counted bytes reach the amount that the selector calls for, the block pulses `mac_start` toward the MAC. At the same moment it latches the per-frame options that the MAC must use for that frame. The MAC then stays busy until it pulses `mac_done`.

A bad length, or a length that has no command written before it, is refused. Such a write sets a sticky error flag that a status read clears. A command with the force option also asks the buffer to drop the data it holds. A fresh command is needed for every frame.

Top module: `tx_bid_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, `ready`, `bid_err`, `irq`, `mac_start`, `buf_flush` and all `tx_*` outputs are low.
- R2: A length write with a value of 0 or above 1514 is refused: `bid_err` goes high on the next cycle and `ready` stays low. A length of 1514 is accepted.
- R3: A length write with no command written since the last length write is refused and sets `bid_err`. Every frame therefore needs its own command write.
- R4: `bid_err` stays high until a cycle with `stat_rd` high, and reads low from the next cycle. A refusal in the same cycle as the read keeps it high.
- R5: `ready` goes high on the cycle after a valid length is accepted while the MAC is idle. It goes low on the cycle after any command write.
- R6: `cmd_start_sel` selects the byte threshold: 2'b00 means 5 bytes, 2'b01 means 381, 2'b10 means 1021, and 2'b11 means the whole frame. `mac_start` is high for exactly one cycle, the cycle after the byte write that reaches the threshold.
- R7: When the frame length is below the selected threshold, `mac_start` follows the byte write that completes the frame.
- R8: `ready` is low in the cycle where `mac_start` is high. Byte writes made while `ready` is low are not counted.
- R9: A valid bid accepted while the MAC is busy keeps `ready` low. `ready` rises on the cycle after `mac_done`.
- R10: `irq` equals `ready` when `irq_en` is high and is low otherwise.
- R11: A command write with `cmd_force` high makes `buf_flush` high for the single following cycle.
- R12: `tx_one_try`, `tx_no_fcs`, `tx_no_pad` and `tx_len` take the values of the started frame's command and length from the `mac_start` cycle on. They hold those values until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_start_sel | input | 2 | Start threshold selector |
| cmd_force | input | 1 | Discard buffered data |
| cmd_one_try | input | 1 | No retry after collision |
| cmd_no_fcs | input | 1 | Do not append CRC |
| cmd_no_pad | input | 1 | Do not pad short frames |
| len_wr | input | 1 | Length write strobe |
| len_val | input | LEN_W | Frame length in bytes |
| stat_rd | input | 1 | Status read strobe, clears bid error |
| irq_en | input | 1 | Interrupt mode enable |
| data_wr | input | 1 | One frame byte written to buffer |
| mac_done | input | 1 | MAC finished the frame |
| ready | output | 1 | Buffer space granted, host may write |
| bid_err | output | 1 | Sticky bid error |
| irq | output | 1 | Ready interrupt |
| buf_flush | output | 1 | Discard buffer contents pulse |
| mac_start | output | 1 | Begin preamble pulse |
| tx_one_try | output | 1 | Active frame: single attempt |
| tx_no_fcs | output | 1 | Active frame: CRC inhibited |
| tx_no_pad | output | 1 | Active frame: padding disabled |
| tx_len | output | LEN_W | Active frame length |

## Verification
The hardest situation to reach is a second bid that is accepted while the MAC is still sending the first frame. In that case `ready` must stay low through the busy period and rise only after `mac_done`. The stimulus gets there by starting a short frame with the 5-byte threshold, writing a full new bid while holding `mac_done` low for several cycles, and only then releasing it.

The thresholds of 381 and 1021 bytes, and the length of exactly 1514, are reached by long unbroken runs of byte writes. The check one write before each threshold confirms that no start comes early.

// File: rtl/tx_bid_pkg.sv
package tx_bid_pkg;

    typedef enum logic [1:0] {
        START_T0    = 2'b00,
        START_T1    = 2'b01,
        START_T2    = 2'b10,
        START_WHOLE = 2'b11
    } start_sel_e;

    typedef struct packed {
        logic one_try;
        logic no_fcs;
        logic no_pad;
    } tx_opt_t;

    typedef struct packed {
        start_sel_e sel;
        tx_opt_t    opt;
    } tx_bid_t;

    // Bytes needed before the preamble may begin: the selected threshold,
    // but never more than the frame itself.
    function automatic int unsigned start_need(start_sel_e sel, int unsigned len,
                                               int unsigned t0, int unsigned t1,
                                               int unsigned t2);
        int unsigned th;
        case (sel)
            START_T0: th = t0;
            START_T1: th = t1;
            START_T2: th = t2;
            default:  th = len;
        endcase
        return (th < len) ? th : len;
    endfunction

endpackage

// File: rtl/tx_bid_check.sv
module tx_bid_check
    import tx_bid_pkg::*;
#(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MAX_LEN = 1514
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  tx_bid_t          cmd_bid,
    input  logic             cmd_force,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             stat_rd,
    input  logic             launch,
    output logic             armed,
    output tx_bid_t          bid,
    output logic [LEN_W-1:0] bid_len,
    output logic             bid_err,
    output logic             buf_flush,
    output logic             accept
);

    logic cmd_valid;
    logic len_ok;
    logic reject;

    assign len_ok = cmd_valid && (len_val != '0) && (32'(len_val) <= MAX_LEN);
    assign accept = len_wr && !cmd_wr && len_ok;
    assign reject = len_wr && !cmd_wr && !len_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_valid <= 1'b0;
            armed     <= 1'b0;
            bid       <= '0;
            bid_len   <= '0;
            bid_err   <= 1'b0;
            buf_flush <= 1'b0;
        end else begin
            buf_flush <= cmd_wr & cmd_force;
            if (launch) begin
                armed <= 1'b0;
            end
            if (cmd_wr) begin
                cmd_valid <= 1'b1;
                bid       <= cmd_bid;
                armed     <= 1'b0;
            end else if (len_wr) begin
                cmd_valid <= 1'b0;
                if (len_ok) begin
                    armed   <= 1'b1;
                    bid_len <= len_val;
                end
            end
            if (reject) begin
                bid_err <= 1'b1;
            end else if (stat_rd) begin
                bid_err <= 1'b0;
            end
        end
    end

    AST_BAD_LEN_FLAGGED: assert property (@(posedge clk) disable iff (rst)
        len_wr && !cmd_wr && ((len_val == '0) || (32'(len_val) > MAX_LEN)) |=> bid_err); // R2
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        bid_err && !stat_rd |=> bid_err); // R4
    AST_BAD_LEN_NOT_ARMED: assert property (@(posedge clk) disable iff (rst)
        len_wr && !cmd_wr && (len_val == '0) && !armed |=> !armed); // R2

endmodule

// File: rtl/tx_start_gate.sv
module tx_start_gate
    import tx_bid_pkg::*;
#(
    parameter int unsigned LEN_W = 11,
    parameter int unsigned TH0   = 5,
    parameter int unsigned TH1   = 381,
    parameter int unsigned TH2   = 1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             ready,
    input  logic             data_wr,
    input  tx_bid_t          bid,
    input  logic [LEN_W-1:0] bid_len,
    output logic             hit
);

    logic [LEN_W-1:0] cnt;
    logic [LEN_W-1:0] cnt_inc;
    logic [LEN_W-1:0] need;
    logic             take;

    assign take    = ready && data_wr;
    assign cnt_inc = cnt + LEN_W'(take);
    assign need    = LEN_W'(start_need(bid.sel, 32'(bid_len), TH0, TH1, TH2));
    assign hit     = take && (cnt_inc >= need);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (take) begin
            cnt <= cnt_inc;
        end
    end

    AST_COUNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !ready && !clear |=> $stable(cnt)); // R8

endmodule

// File: rtl/tx_mac_track.sv
module tx_mac_track
    import tx_bid_pkg::*;
#(
    parameter int unsigned LEN_W = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             launch,
    input  logic             mac_done,
    input  tx_bid_t          bid,
    input  logic [LEN_W-1:0] bid_len,
    output logic             busy,
    output logic             mac_start,
    output tx_opt_t          act_opt,
    output logic [LEN_W-1:0] act_len
);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            mac_start <= 1'b0;
            act_opt   <= '0;
            act_len   <= '0;
        end else begin
            mac_start <= launch;
            if (launch) begin
                busy    <= 1'b1;
                act_opt <= bid.opt;
                act_len <= bid_len;
            end else if (mac_done) begin
                busy <= 1'b0;
            end
        end
    end

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        mac_start |=> !mac_start); // R6
    AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
        mac_start |-> busy); // R9

endmodule

// File: rtl/tx_bid_ctrl.sv
module tx_bid_ctrl
    import tx_bid_pkg::*;
#(
    parameter int unsigned LEN_W   = 11,
    parameter int unsigned MAX_LEN = 1514,
    parameter int unsigned TH0     = 5,
    parameter int unsigned TH1     = 381,
    parameter int unsigned TH2     = 1021
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd_start_sel,
    input  logic             cmd_force,
    input  logic             cmd_one_try,
    input  logic             cmd_no_fcs,
    input  logic             cmd_no_pad,
    input  logic             len_wr,
    input  logic [LEN_W-1:0] len_val,
    input  logic             stat_rd,
    input  logic             irq_en,
    input  logic             data_wr,
    input  logic             mac_done,
    output logic             ready,
    output logic             bid_err,
    output logic             irq,
    output logic             buf_flush,
    output logic             mac_start,
    output logic             tx_one_try,
    output logic             tx_no_fcs,
    output logic             tx_no_pad,
    output logic [LEN_W-1:0] tx_len
);

    tx_bid_t          cmd_bid;
    tx_bid_t          bid;
    tx_opt_t          act_opt;
    logic [LEN_W-1:0] bid_len;
    logic             armed;
    logic             accept;
    logic             launch;
    logic             busy;

    assign cmd_bid.sel         = start_sel_e'(cmd_start_sel);
    assign cmd_bid.opt.one_try = cmd_one_try;
    assign cmd_bid.opt.no_fcs  = cmd_no_fcs;
    assign cmd_bid.opt.no_pad  = cmd_no_pad;

    assign ready      = armed & ~busy;
    assign irq        = ready & irq_en;
    assign tx_one_try = act_opt.one_try;
    assign tx_no_fcs  = act_opt.no_fcs;
    assign tx_no_pad  = act_opt.no_pad;

    tx_bid_check #(.LEN_W(LEN_W), .MAX_LEN(MAX_LEN)) i_check (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd_bid   (cmd_bid),
        .cmd_force (cmd_force),
        .len_wr    (len_wr),
        .len_val   (len_val),
        .stat_rd   (stat_rd),
        .launch    (launch),
        .armed     (armed),
        .bid       (bid),
        .bid_len   (bid_len),
        .bid_err   (bid_err),
        .buf_flush (buf_flush),
        .accept    (accept)
    );

    tx_start_gate #(.LEN_W(LEN_W), .TH0(TH0), .TH1(TH1), .TH2(TH2)) i_gate (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .ready   (ready),
        .data_wr (data_wr),
        .bid     (bid),
        .bid_len (bid_len),
        .hit     (launch)
    );

    tx_mac_track #(.LEN_W(LEN_W)) i_mac (
        .clk       (clk),
        .rst       (rst),
        .launch    (launch),
        .mac_done  (mac_done),
        .bid       (bid),
        .bid_len   (bid_len),
        .busy      (busy),
        .mac_start (mac_start),
        .act_opt   (act_opt),
        .act_len   (tx_len)
    );

    AST_START_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        mac_start |-> !ready); // R8
    AST_START_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
        mac_start |-> $past(data_wr)); // R6
    AST_CMD_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
        cmd_wr |=> !ready); // R5

endmodule

// File: tb/test_tx_bid_ctrl.sv
module test_tx_bid_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_wr = 1'b0;
    logic [1:0]  cmd_start_sel = 2'b00;
    logic        cmd_force = 1'b0;
    logic        cmd_one_try = 1'b0;
    logic        cmd_no_fcs = 1'b0;
    logic        cmd_no_pad = 1'b0;
    logic        len_wr = 1'b0;
    logic [10:0] len_val = '0;
    logic        stat_rd = 1'b0;
    logic        irq_en = 1'b0;
    logic        data_wr = 1'b0;
    logic        mac_done = 1'b0;
    logic        ready, bid_err, irq, buf_flush, mac_start;
    logic        tx_one_try, tx_no_fcs, tx_no_pad;
    logic [10:0] tx_len;

    int n_chk = 0;
    int n_fail = 0;
    int wd = 0;
    bit fin = 1'b0;

    always #2.5 clk = ~clk;

    tx_bid_ctrl i_tx_bid_ctrl (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_start_sel(cmd_start_sel),
        .cmd_force(cmd_force), .cmd_one_try(cmd_one_try), .cmd_no_fcs(cmd_no_fcs),
        .cmd_no_pad(cmd_no_pad), .len_wr(len_wr), .len_val(len_val),
        .stat_rd(stat_rd), .irq_en(irq_en), .data_wr(data_wr), .mac_done(mac_done),
        .ready(ready), .bid_err(bid_err), .irq(irq), .buf_flush(buf_flush),
        .mac_start(mac_start), .tx_one_try(tx_one_try), .tx_no_fcs(tx_no_fcs),
        .tx_no_pad(tx_no_pad), .tx_len(tx_len)
    );

    // Behavioural reference model
    bit m_cv, m_armed, m_busy, m_err, m_start, m_flush, m_rdy, m_old_busy;
    int m_cnt, m_sel, m_blen, m_alen;
    bit [2:0] m_bopt, m_aopt;

    function automatic int need_of(int sel, int len);
        int th;
        th = (sel == 0) ? 5 : (sel == 1) ? 381 : (sel == 2) ? 1021 : len;
        return (th < len) ? th : len;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cv = 0; m_armed = 0; m_busy = 0; m_err = 0; m_start = 0; m_flush = 0;
            m_cnt = 0; m_sel = 0; m_blen = 0; m_alen = 0; m_bopt = 0; m_aopt = 0;
        end else begin
            m_rdy = m_armed && !m_busy;
            m_old_busy = m_busy;
            m_start = 0;
            m_flush = 0;
            if (stat_rd) m_err = 0;
            if (cmd_wr) begin
                m_cv = 1; m_sel = int'(cmd_start_sel);
                m_bopt = {cmd_one_try, cmd_no_fcs, cmd_no_pad};
                m_armed = 0; m_flush = cmd_force;
            end else if (len_wr) begin
                if (m_cv && len_val >= 1 && len_val <= 1514) begin
                    m_armed = 1; m_blen = int'(len_val); m_cnt = 0;
                end else begin
                    m_err = 1;
                end
                m_cv = 0;
            end
            if (data_wr && m_rdy) begin
                m_cnt++;
                if (m_cnt >= need_of(m_sel, m_blen)) begin
                    m_armed = 0; m_busy = 1; m_start = 1;
                    m_aopt = m_bopt; m_alen = m_blen;
                end
            end
            if (m_old_busy && mac_done) m_busy = 0;
        end
    end

    task automatic chk(bit ok, string tag, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !fin) begin
            chk(ready == (m_armed && !m_busy), "R5 ready", int'(ready), int'(m_armed && !m_busy));
            chk(bid_err == m_err, "R2 bid_err", int'(bid_err), int'(m_err));
            chk(irq == (m_armed && !m_busy && irq_en), "R10 irq", int'(irq),
                int'(m_armed && !m_busy && irq_en));
            chk(mac_start == m_start, "R6 mac_start", int'(mac_start), int'(m_start));
            chk(buf_flush == m_flush, "R11 buf_flush", int'(buf_flush), int'(m_flush));
            chk({tx_one_try, tx_no_fcs, tx_no_pad} == m_aopt, "R12 options",
                int'({tx_one_try, tx_no_fcs, tx_no_pad}), int'(m_aopt));
            chk(int'(tx_len) == m_alen, "R12 tx_len", int'(tx_len), m_alen);
        end
    end

    task automatic finish_run();
        if (!fin) begin
            fin = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !fin) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
            finish_run();
        end
    end

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic send_cmd(int sel, bit frc, bit one, bit nofcs, bit nopad);
        cmd_wr = 1; cmd_start_sel = sel[1:0]; cmd_force = frc;
        cmd_one_try = one; cmd_no_fcs = nofcs; cmd_no_pad = nopad;
        cyc();
        cmd_wr = 0; cmd_force = 0;
    endtask

    task automatic send_len(int len);
        len_wr = 1; len_val = len[10:0];
        cyc();
        len_wr = 0;
    endtask

    task automatic bid(int sel, bit one, bit nofcs, bit nopad, int len);
        send_cmd(sel, 1'b0, one, nofcs, nopad);
        send_len(len);
    endtask

    task automatic put(int n);
        if (n > 0) begin
            data_wr = 1;
            repeat (n) cyc();
            data_wr = 0;
        end
    endtask

    task automatic done();
        mac_done = 1;
        cyc();
        mac_done = 0;
    endtask

    task automatic rd_stat();
        stat_rd = 1;
        cyc();
        stat_rd = 0;
    endtask

    initial begin
        repeat (3) cyc();
        @(negedge clk);
        chk({ready, bid_err, irq, mac_start, buf_flush} == 5'b0, "R1 outputs in reset",
            int'({ready, bid_err, irq, mac_start, buf_flush}), 0);
        cyc();
        rst = 0;
        cyc();
        @(negedge clk);
        chk({ready, bid_err, mac_start, tx_len} == '0, "R1 after reset",
            int'({ready, bid_err, mac_start, tx_len}), 0);

        // R3: length with no command
        send_len(60);
        @(negedge clk);
        chk(bid_err == 1, "R3 orphan length", int'(bid_err), 1);
        repeat (3) cyc();
        @(negedge clk);
        chk(bid_err == 1, "R4 sticky", int'(bid_err), 1);
        rd_stat();
        @(negedge clk);
        chk(bid_err == 0, "R4 cleared by read", int'(bid_err), 0);

        // R2: bad lengths
        bid(0, 0, 0, 0, 0);
        @(negedge clk);
        chk(bid_err == 1 && ready == 0, "R2 zero length", int'({bid_err, ready}), 2);
        rd_stat();
        bid(0, 0, 0, 0, 1515);
        @(negedge clk);
        chk(bid_err == 1 && ready == 0, "R2 too long", int'({bid_err, ready}), 2);
        rd_stat();

        // R6 threshold 5, interrupt mode
        irq_en = 1;
        bid(0, 1, 0, 1, 60);
        @(negedge clk);
        chk(ready == 1, "R5 ready after bid", int'(ready), 1);
        chk(irq == 1, "R10 irq enabled", int'(irq), 1);
        put(4);
        @(negedge clk);
        chk(mac_start == 0, "R6 no early start at 4", int'(mac_start), 0);
        put(1);
        @(negedge clk);
        chk(mac_start == 1, "R6 start at 5", int'(mac_start), 1);
        chk(ready == 0, "R8 ready low at start", int'(ready), 0);
        chk(tx_one_try == 1 && tx_no_pad == 1 && tx_len == 11'd60, "R12 options latched",
            int'(tx_len), 60);
        put(10);
        done();

        // R6 threshold 381, poll mode
        irq_en = 0;
        bid(1, 0, 1, 0, 400);
        @(negedge clk);
        chk(ready == 1 && irq == 0, "R10 irq masked", int'(irq), 0);
        put(380);
        @(negedge clk);
        chk(mac_start == 0, "R6 no start at 380", int'(mac_start), 0);
        put(1);
        @(negedge clk);
        chk(mac_start == 1, "R6 start at 381", int'(mac_start), 1);
        done();
        @(negedge clk);
        chk(tx_no_fcs == 1 && tx_len == 11'd400, "R12 held after done", int'(tx_len), 400);

        // R6 threshold 1021, maximum length accepted (R2)
        bid(2, 0, 0, 0, 1514);
        @(negedge clk);
        chk(bid_err == 0 && ready == 1, "R2 1514 accepted", int'({bid_err, ready}), 1);
        put(1020);
        @(negedge clk);
        chk(mac_start == 0, "R6 no start at 1020", int'(mac_start), 0);
        put(1);
        @(negedge clk);
        chk(mac_start == 1, "R6 start at 1021", int'(mac_start), 1);
        done();

        // R6 whole frame
        bid(3, 0, 0, 0, 100);
        put(99);
        @(negedge clk);
        chk(mac_start == 0, "R6 whole frame not yet", int'(mac_start), 0);
        put(1);
        @(negedge clk);
        chk(mac_start == 1, "R6 whole frame start", int'(mac_start), 1);
        done();

        // R7 frame shorter than threshold
        bid(1, 0, 0, 0, 100);
        put(99);
        @(negedge clk);
        chk(mac_start == 0, "R7 short frame not yet", int'(mac_start), 0);
        put(1);
        @(negedge clk);
        chk(mac_start == 1, "R7 short frame start", int'(mac_start), 1);
        done();

        // R9 bid while MAC busy
        bid(0, 0, 0, 0, 20);
        put(5);
        bid(0, 0, 1, 1, 30);
        @(negedge clk);
        chk(ready == 0, "R9 held while busy", int'(ready), 0);
        repeat (3) cyc();
        @(negedge clk);
        chk(ready == 0, "R9 still held", int'(ready), 0);
        done();
        @(negedge clk);
        chk(ready == 1, "R9 ready after done", int'(ready), 1);
        put(5);
        @(negedge clk);
        chk(mac_start == 1 && tx_len == 11'd30, "R12 queued bid used", int'(tx_len), 30);
        done();

        // R8 bytes while not ready are ignored
        put(10);
        bid(0, 0, 0, 0, 50);
        put(4);
        @(negedge clk);
        chk(mac_start == 0, "R8 stray bytes not counted", int'(mac_start), 0);
        put(1);
        done();

        // R5 command clears ready
        bid(3, 0, 0, 0, 40);
        send_cmd(3, 1'b0, 0, 0, 0);
        @(negedge clk);
        chk(ready == 0, "R5 cleared by command", int'(ready), 0);
        send_len(40);
        put(40);
        done();

        // R11 force flush
        cmd_wr = 1; cmd_force = 1; cmd_start_sel = 2'b00;
        cyc();
        cmd_wr = 0; cmd_force = 0;
        @(negedge clk);
        chk(buf_flush == 1, "R11 flush pulse", int'(buf_flush), 1);
        send_len(10);
        @(negedge clk);
        chk(buf_flush == 0, "R11 flush one cycle", int'(buf_flush), 0);
        put(5);
        done();

        // R3 fresh command required per frame
        send_len(10);
        @(negedge clk);
        chk(bid_err == 1 && ready == 0, "R3 reused command refused", int'({bid_err, ready}), 2);
        stat_rd = 1; len_wr = 1; len_val = 11'd0;
        cyc();
        stat_rd = 0; len_wr = 0;
        @(negedge clk);
        chk(bid_err == 1, "R4 refusal beats read", int'(bid_err), 1);
        rd_stat();

        repeat (3) cyc();
        finish_run();
    end

endmodule